// File: doc/BRIEF.md
# I2C Master Command and Data FIFO Front End

This block sits between a register bus and a byte-level I2C bus engine. Software queues work through a single data/command register: each write becomes either a byte to transmit or a request to receive one byte, and both kinds wait in one transmit FIFO so that they reach the bus in the order they were written. Bytes that the engine receives are placed in a receive FIFO, and software collects them by reading the same data/command register.

A small sequencer drains the transmit FIFO towards the engine over a valid/ready handshake. It has four states. OFF holds while the controller is disabled. IDLE waits with the controller enabled and nothing queued. SEND offers the head entry. AWAIT waits for the byte answering a read request. The transitions are: any state to OFF when disabled, OFF to IDLE once enabled, IDLE to SEND when the transmit FIFO is not empty, SEND to AWAIT when a read request is accepted, SEND to IDLE when the FIFO has drained, and AWAIT to SEND when the engine strobes a received byte. At most one read is in flight at a time, and a read is not offered while the receive FIFO has no room. Software also has fill-level registers, a parameter register giving both FIFO depths, an enable register, and target address and address-width controls. The address controls can be changed only while the controller is disabled.

Register word addresses: 0 control (bit 4 selects 10-bit addressing), 1 target address (bits 9:0), 4 data/command, 5 enable (bit 0), 6 status (bit 0 active), 7 transmit level, 8 receive level, 9 error flags (bit 0 transmit overflow, bit 1 receive underflow), 10 parameters.

Top module: `i2cf_top`

## Requirements
- R1: A write to address 4 with bit 8 clear queues bits 7:0 as a write entry; the engine later sees it with `cmd_read`=0 and `cmd_byte` equal to that byte.
- R2: A write to address 4 with bit 8 set queues a read request; bits 7:0 are ignored and the engine sees `cmd_read`=1 with `cmd_byte`=0.
- R3: A read of address 4 returns the oldest received byte in bits 7:0, one cycle after the read strobe, and removes it from the receive FIFO.
- R4: Addresses 7 and 8 return the current transmit and receive fill levels.
- R5: Address 10 returns transmit depth minus one in bits 23:16 and receive depth minus one in bits 15:8, all other bits zero.
- R6: After reset the controller is disabled. Writing 1 to bit 0 of address 5 enables it and writing 0 disables it. While it is disabled, no command is offered, both FIFOs are empty and data/command writes are discarded.
- R7: The target address (address 1) and 10-bit mode (address 0 bit 4) take writes only while disabled; they drive `tgt_addr` and `tgt_ten_bit` and read back unchanged after a write made while enabled.
- R8: Status bit 0 reads 1 while the sequencer is in SEND or AWAIT, and 0 otherwise.
- R9: A data/command write to a full transmit FIFO is dropped, and error-flag bit 0 is set; reading address 9 returns the flags and clears them.
- R10: A data/command read from an empty receive FIFO returns 0 and sets error-flag bit 1.
- R11: After a read request is accepted, no further command is offered until `rx_valid` arrives, and no read request is offered while the receive FIFO is full.
- R12: Commands reach the engine in write order, and an offered command holds its value until `cmd_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| cmd_valid | output | 1 | Command offered to the engine |
| cmd_ready | input | 1 | Engine accepts the command |
| cmd_read | output | 1 | 1 = read request, 0 = write byte |
| cmd_byte | output | 8 | Byte to transmit (0 for reads) |
| tgt_addr | output | 10 | Programmed target address |
| tgt_ten_bit | output | 1 | 10-bit addressing selected |
| rx_valid | input | 1 | Engine strobe for a received byte |
| rx_byte | input | 8 | Received byte |

## Verification
A register read returns data one cycle after its strobe, so the bench drives each access on a falling edge and samples `reg_rdata` on the next falling edge. Level and flag changes from a write take effect at the same rising edge. The sequencer needs one more edge to leave IDLE, so a command appears on `cmd_valid` one cycle after the write that queues it. The engine model reacts just after each falling edge and logs every handshake. Checks on `cmd_valid`, ordering and levels are taken only after settle windows that cover the configured response latency plus these register stages.

// File: rtl/i2cf_pkg.sv
package i2cf_pkg;

    localparam int REG_AW = 4;

    localparam logic [REG_AW-1:0] A_CTRL    = 4'd0;
    localparam logic [REG_AW-1:0] A_TARGET  = 4'd1;
    localparam logic [REG_AW-1:0] A_DATACMD = 4'd4;
    localparam logic [REG_AW-1:0] A_ENABLE  = 4'd5;
    localparam logic [REG_AW-1:0] A_STATUS  = 4'd6;
    localparam logic [REG_AW-1:0] A_TXLVL   = 4'd7;
    localparam logic [REG_AW-1:0] A_RXLVL   = 4'd8;
    localparam logic [REG_AW-1:0] A_FLAGS   = 4'd9;
    localparam logic [REG_AW-1:0] A_PARAM   = 4'd10;

    localparam int CMD_RD_BIT  = 8;
    localparam int TEN_BIT_POS = 4;

    typedef struct packed {
        logic       rd;
        logic [7:0] dat;
    } tx_entry_t;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_IDLE,
        ST_SEND,
        ST_AWAIT
    } seq_state_t;

endpackage

// File: rtl/i2cf_fifo.sv
module i2cf_fifo #(
    parameter int WIDTH = 9,
    parameter int DEPTH = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             full,
    output logic             empty,
    output logic [LVL_W-1:0] level
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [LVL_W-1:0] cnt;
    logic             do_push, do_pop;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (cnt == LVL_W'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign head    = mem[rd_ptr];
    assign level   = cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            unique case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    // R6: a flush empties the queue at the next edge
    a_r6_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (level == '0));

    // R9: a push into a full queue without a pop leaves the level alone
    a_r9_full_push_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !flush) |=> $stable(level));

endmodule

// File: rtl/i2cf_seq.sv
module i2cf_seq
    import i2cf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic tx_empty,
    input  logic head_read,
    input  logic rx_full,
    input  logic cmd_ready,
    input  logic rx_valid,
    output logic cmd_valid,
    output logic tx_pop,
    output logic rx_push,
    output logic active
);

    seq_state_t state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        if (!en) begin
            state_nx = ST_OFF;
        end else begin
            unique case (state)
                ST_OFF:   state_nx = ST_IDLE;
                ST_IDLE:  if (!tx_empty) state_nx = ST_SEND;
                ST_SEND: begin
                    if (cmd_valid && cmd_ready && head_read) state_nx = ST_AWAIT;
                    else if (tx_empty)                       state_nx = ST_IDLE;
                end
                ST_AWAIT: if (rx_valid) state_nx = ST_SEND;
                default:  state_nx = ST_OFF;
            endcase
        end
    end

    always_comb begin
        cmd_valid = (state == ST_SEND) && !tx_empty && !(head_read && rx_full);
        tx_pop    = cmd_valid && cmd_ready;
        rx_push   = (state == ST_AWAIT) && rx_valid;
        active    = (state == ST_SEND) || (state == ST_AWAIT);
    end

    // R11: nothing is offered while a read answer is still outstanding
    a_r11_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_AWAIT && !rx_valid) |=> !cmd_valid);

    // R6: a disabled controller offers nothing on the following cycle
    a_r6_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !cmd_valid);

endmodule

// File: rtl/i2cf_top.sv
module i2cf_top
    import i2cf_pkg::*;
#(
    parameter int TX_DEPTH = 8,
    parameter int RX_DEPTH = 8,
    localparam int TX_LVL_W = $clog2(TX_DEPTH + 1),
    localparam int RX_LVL_W = $clog2(RX_DEPTH + 1),
    localparam int ENTRY_W  = $bits(tx_entry_t)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic              cmd_read,
    output logic [7:0]        cmd_byte,
    output logic [9:0]        tgt_addr,
    output logic              tgt_ten_bit,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte
);

    logic                en_q, ten_q, ovf_q, unf_q;
    logic [9:0]          tgt_q;
    logic [31:0]         rdata_q, rdata_nx;
    tx_entry_t           tx_in, tx_head;
    logic [ENTRY_W-1:0]  tx_head_raw;
    logic                tx_push, tx_pop, tx_full, tx_empty;
    logic [TX_LVL_W-1:0] tx_level;
    logic                rx_push, rx_pop, rx_full, rx_empty;
    logic [7:0]          rx_head;
    logic [RX_LVL_W-1:0] rx_level;
    logic                active;
    logic                wr_dc, rd_dc, rd_flags, dis_wr;
    logic                unused_wdata;

    assign unused_wdata = ^reg_wdata[31:10];

    assign wr_dc    = reg_wr && (reg_addr == A_DATACMD);
    assign rd_dc    = reg_rd && (reg_addr == A_DATACMD);
    assign rd_flags = reg_rd && (reg_addr == A_FLAGS);
    assign dis_wr   = reg_wr && (reg_addr == A_ENABLE) && !reg_wdata[0];

    assign tx_push = wr_dc && en_q;
    assign tx_in   = '{rd:  reg_wdata[CMD_RD_BIT],
                       dat: reg_wdata[CMD_RD_BIT] ? 8'h00 : reg_wdata[7:0]};
    assign rx_pop  = rd_dc;

    i2cf_fifo #(.WIDTH(ENTRY_W), .DEPTH(TX_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(!en_q),
        .push(tx_push), .push_data(tx_in), .pop(tx_pop),
        .head(tx_head_raw), .full(tx_full), .empty(tx_empty), .level(tx_level)
    );

    i2cf_fifo #(.WIDTH(8), .DEPTH(RX_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(!en_q),
        .push(rx_push), .push_data(rx_byte), .pop(rx_pop),
        .head(rx_head), .full(rx_full), .empty(rx_empty), .level(rx_level)
    );

    assign tx_head = tx_entry_t'(tx_head_raw);

    i2cf_seq u_seq (
        .clk(clk), .rst_n(rst_n), .en(en_q),
        .tx_empty(tx_empty), .head_read(tx_head.rd), .rx_full(rx_full),
        .cmd_ready(cmd_ready), .rx_valid(rx_valid),
        .cmd_valid(cmd_valid), .tx_pop(tx_pop), .rx_push(rx_push), .active(active)
    );

    assign cmd_read    = tx_head.rd;
    assign cmd_byte    = tx_head.dat;
    assign tgt_addr    = tgt_q;
    assign tgt_ten_bit = ten_q;
    assign reg_rdata   = rdata_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            ten_q <= 1'b0;
            tgt_q <= '0;
        end else if (reg_wr) begin
            unique case (reg_addr)
                A_ENABLE: en_q <= reg_wdata[0];
                A_CTRL:   if (!en_q) ten_q <= reg_wdata[TEN_BIT_POS];
                A_TARGET: if (!en_q) tgt_q <= reg_wdata[9:0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
            unf_q <= 1'b0;
        end else begin
            ovf_q <= (ovf_q && !rd_flags) || (tx_push && tx_full);
            unf_q <= (unf_q && !rd_flags) || (rd_dc && rx_empty);
        end
    end

    always_comb begin
        rdata_nx = '0;
        unique case (reg_addr)
            A_CTRL:    rdata_nx[TEN_BIT_POS] = ten_q;
            A_TARGET:  rdata_nx[9:0] = tgt_q;
            A_DATACMD: rdata_nx[7:0] = rx_empty ? 8'h00 : rx_head;
            A_ENABLE:  rdata_nx[0] = en_q;
            A_STATUS:  rdata_nx[0] = active;
            A_TXLVL:   rdata_nx[TX_LVL_W-1:0] = tx_level;
            A_RXLVL:   rdata_nx[RX_LVL_W-1:0] = rx_level;
            A_FLAGS:   rdata_nx[1:0] = {unf_q, ovf_q};
            A_PARAM:   rdata_nx[23:8] = {8'(TX_DEPTH - 1), 8'(RX_DEPTH - 1)};
            default:   rdata_nx = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      rdata_q <= '0;
        else if (reg_rd) rdata_q <= rdata_nx;
    end

    // R12: an offered command keeps its value until accepted
    a_r12_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready && en_q && !dis_wr)
        |=> (cmd_valid && $stable(cmd_read) && $stable(cmd_byte)));

    // R7: address controls cannot move while enabled
    a_r7_target_locked: assert property (@(posedge clk) disable iff (!rst_n)
        en_q |=> ($stable(tgt_q) && $stable(ten_q)));

    // R2: a read request never carries a data byte
    a_r2_read_byte_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_read) |-> (cmd_byte == 8'h00));

    // R11: a read is never offered into a full receive FIFO
    a_r11_read_room: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_read) |-> !rx_full);

endmodule

// File: tb/tb_i2cf_top.sv
module tb_i2cf_top;

    localparam int TXD = 4;
    localparam int RXD = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        cmd_valid, cmd_ready, cmd_read;
    logic [7:0]  cmd_byte;
    logic [9:0]  tgt_addr;
    logic        tgt_ten_bit;
    logic        rx_valid;
    logic [7:0]  rx_byte;

    int checks = 0, fails = 0;
    logic        eng_stall = 1'b1;
    int          rx_lat = 3;
    int          cnt_down = 0;
    bit          outstanding = 0;
    int          early = 0;
    logic [7:0]  resp_seq = 8'hC0;
    logic [8:0]  log_q[$];

    always #2.5 clk = ~clk;

    i2cf_top #(.TX_DEPTH(TXD), .RX_DEPTH(RXD)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_read(cmd_read),
        .cmd_byte(cmd_byte), .tgt_addr(tgt_addr), .tgt_ten_bit(tgt_ten_bit),
        .rx_valid(rx_valid), .rx_byte(rx_byte)
    );

    // bus engine model: acts just after each falling edge
    initial begin
        cmd_ready = 1'b0;
        rx_valid  = 1'b0;
        rx_byte   = 8'h00;
        forever begin
            @(negedge clk);
            #1;
            rx_valid = 1'b0;
            if (cnt_down > 0) begin
                cnt_down--;
                if (cnt_down == 0) begin
                    rx_valid    = 1'b1;
                    rx_byte     = resp_seq;
                    resp_seq    = resp_seq + 8'd1;
                    outstanding = 0;
                end
            end
            cmd_ready = !eng_stall;
            if (cmd_valid && cmd_ready) begin
                if (outstanding) early++;
                log_q.push_back({cmd_read, cmd_byte});
                if (cmd_read) begin
                    outstanding = 1;
                    cnt_down    = rx_lat;
                end
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        d = reg_rdata;
        reg_rd = 1'b0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        reg_read(4'd5, d);  check("R6 reset disabled", d, 32'h0);
        reg_read(4'd7, d);  check("R4 reset tx level", d, 32'h0);
        reg_read(4'd6, d);  check("R8 reset status", d, 32'h0);
        reg_read(4'd10, d); check("R5 parameter fields", d, ((TXD - 1) << 16) | ((RXD - 1) << 8));
        check("R6 reset no command", {31'h0, cmd_valid}, 32'h0);
    endtask

    task automatic t_disabled_setup();
        logic [31:0] d;
        reg_write(4'd4, 32'h0000_0077);
        reg_read(4'd7, d);  check("R6 write discarded while disabled", d, 32'h0);
        reg_write(4'd1, 32'h0000_02A5);
        reg_write(4'd0, 32'h0000_0010);
        reg_read(4'd1, d);  check("R7 target readback", d, 32'h2A5);
        check("R7 target port", {22'h0, tgt_addr}, 32'h2A5);
        check("R7 ten-bit port", {31'h0, tgt_ten_bit}, 32'h1);
    endtask

    task automatic t_write_order();
        logic [31:0] d;
        eng_stall = 1'b1;
        log_q.delete();
        reg_write(4'd5, 32'h1);
        reg_write(4'd4, 32'h0000_0011);
        reg_write(4'd4, 32'h0000_FE22);
        reg_write(4'd4, 32'h0000_0033);
        reg_read(4'd7, d);  check("R4 tx level three", d, 32'h3);
        reg_read(4'd6, d);  check("R8 status active", d, 32'h1);
        check("R12 first offered", {23'h0, cmd_read, cmd_byte}, 32'h011);
        settle(5);
        check("R12 held while stalled", {22'h0, cmd_valid, cmd_read, cmd_byte}, 32'h211);
        reg_write(4'd1, 32'h0000_0011);
        reg_write(4'd0, 32'h0000_0000);
        reg_read(4'd1, d);  check("R7 target kept while enabled", d, 32'h2A5);
        reg_read(4'd0, d);  check("R7 ten-bit kept while enabled", d, 32'h10);
        eng_stall = 1'b0;
        settle(20);
        check("R1 three writes logged", log_q.size(), 32'd3);
        if (log_q.size() == 3) begin
            check("R1 R12 first byte", {23'h0, log_q[0]}, 32'h011);
            check("R1 R12 second byte", {23'h0, log_q[1]}, 32'h022);
            check("R1 R12 third byte", {23'h0, log_q[2]}, 32'h033);
        end
        reg_read(4'd6, d);  check("R8 status idle after drain", d, 32'h0);
    endtask

    task automatic t_overflow();
        logic [31:0] d;
        eng_stall = 1'b1;
        settle(2);
        for (int i = 0; i < TXD + 1; i++) reg_write(4'd4, 32'h40 + i);
        reg_read(4'd7, d);  check("R9 tx level capped", d, TXD);
        reg_read(4'd9, d);  check("R9 overflow flag", d, 32'h1);
        reg_read(4'd9, d);  check("R9 flags cleared by read", d, 32'h0);
        reg_write(4'd5, 32'h0);
        reg_read(4'd7, d);  check("R6 disable flushes tx", d, 32'h0);
        check("R6 no command when disabled", {31'h0, cmd_valid}, 32'h0);
        eng_stall = 1'b0;
        settle(3);
        log_q.delete();
    endtask

    task automatic t_reads();
        logic [31:0] d;
        logic [7:0]  base;
        base  = resp_seq;
        early = 0;
        log_q.delete();
        reg_write(4'd5, 32'h1);
        reg_write(4'd4, 32'h0000_01FF);
        reg_write(4'd4, 32'h0000_005A);
        reg_write(4'd4, 32'h0000_0100);
        settle(30);
        check("R2 R1 mixed commands logged", log_q.size(), 32'd3);
        if (log_q.size() == 3) begin
            check("R2 read request byte ignored", {23'h0, log_q[0]}, 32'h100);
            check("R1 write between reads", {23'h0, log_q[1]}, 32'h05A);
            check("R2 second read request", {23'h0, log_q[2]}, 32'h100);
        end
        check("R11 nothing offered during read", early, 32'd0);
        reg_read(4'd8, d);  check("R4 rx level two", d, 32'h2);
        reg_read(4'd4, d);  check("R3 first received byte", d, {24'h0, base});
        reg_read(4'd4, d);  check("R3 second received byte", d, {24'h0, base + 8'd1});
        reg_read(4'd4, d);  check("R10 empty read returns zero", d, 32'h0);
        reg_read(4'd9, d);  check("R10 underflow flag", d, 32'h2);
    endtask

    task automatic t_rx_full();
        logic [31:0] d;
        logic [7:0]  base;
        base = resp_seq;
        for (int i = 0; i < RXD; i++) reg_write(4'd4, 32'h100);
        settle(40);
        reg_read(4'd8, d);  check("R4 rx level full", d, RXD);
        reg_write(4'd4, 32'h100);
        settle(15);
        check("R11 read withheld when rx full", {31'h0, cmd_valid}, 32'h0);
        reg_read(4'd7, d);  check("R11 request still queued", d, 32'h1);
        reg_read(4'd6, d);  check("R8 active while withheld", d, 32'h1);
        reg_read(4'd4, d);  check("R3 pop makes room", d, {24'h0, base});
        settle(15);
        reg_read(4'd7, d);  check("R11 request issued after room", d, 32'h0);
        reg_read(4'd8, d);  check("R11 rx refilled", d, RXD);
        reg_write(4'd5, 32'h0);
        reg_read(4'd8, d);  check("R6 disable flushes rx", d, 32'h0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_disabled_setup();
        t_write_order();
        t_overflow();
        t_reads();
        t_rx_full();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule